// File: doc/BRIEF.md
# Serial 0-1-1 Pattern Detector with Progress Lights

This block is a clocked Moore machine that watches a one-bit serial stream for the bit sequence 0, then 1, then 1. It does not raise a single hit pulse. It drives a three-bit thermometer that shows how far the current partial match has got. A typical use is to drive three indicator LEDs that fill up as the pattern arrives. The outputs depend only on the registered state, so they change only at a clock edge.

The state is held in two D flip-flops with a Gray-like code. The codes are: waiting = 00, first zero seen = 01, zero-one seen = 11, full pattern seen = 10. The current state code is also brought out so it can be observed. Matches may overlap and may follow one another directly. The zero that follows a full match already counts as the first bit of the next match.

Top module: `seq_progress_top`

## Requirements
- R1: With `rst` high at a rising clock edge, the state becomes 00 and `progress` becomes 000 after that edge.
- R2: From state 00, a 0 on `serialIn` moves the state to 01 and a 1 keeps it at 00.
- R3: From state 01, a 0 keeps the state at 01 and a 1 moves it to 11.
- R4: From state 11, a 0 moves the state back to 01 and a 1 moves it to 10.
- R5: From state 10, a 0 moves the state to 01, so overlapping and back-to-back patterns are found. A 1 moves the state to 00.
- R6: `progress` is a function of the state alone: 000 for 00, 001 for 01, 011 for 11 and 111 for 10. It is always a thermometer code, meaning a set bit implies that every lower bit is set.
- R7: A change on `serialIn` between clock edges leaves `progress` and `stateOut` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | 1 | Serial data bit, sampled every rising edge |
| progress | output | 3 | Thermometer count of matched pattern bits |
| stateOut | output | 2 | Current state code (bit 1 = high flip-flop) |

## Verification
The transition assertions assume that `serialIn` is a known 0 or 1 at every rising edge, and that reset is held for at least one edge before any checks apply. The bench drives `serialIn` only just after falling edges, always with a defined value, and keeps reset high for two edges at start-up and in the middle of the run. The only exception is the mid-cycle test for R7. It toggles the input between edges and then restores a defined value before the next rising edge.

// File: rtl/seq_progress_pkg.sv
package seq_progress_pkg;
  localparam int STATE_W = 2;
  localparam int PROG_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_WAIT = 2'b00,
    ST_ONE  = 2'b01,
    ST_TWO  = 2'b11,
    ST_FULL = 2'b10
  } detState_t;

  // Strobes from control to datapath: the two state flip-flop outputs
  typedef struct packed {
    logic hiBit;
    logic loBit;
  } stateStrobes_t;
endpackage

// File: rtl/seq_progress_ctrl.sv
module seq_progress_ctrl
  import seq_progress_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          serialIn,
  output stateStrobes_t strobes
);
  detState_t curState;
  detState_t nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_WAIT: nextState = serialIn ? ST_WAIT : ST_ONE;
      ST_ONE:  nextState = serialIn ? ST_TWO  : ST_ONE;
      ST_TWO:  nextState = serialIn ? ST_FULL : ST_ONE;
      ST_FULL: nextState = serialIn ? ST_WAIT : ST_ONE;
      default: nextState = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_WAIT;
    else     curState <= nextState;
  end

  assign strobes.hiBit = curState[1];
  assign strobes.loBit = curState[0];

  // R1
  reset_to_wait_chk: assert property (@(posedge clk) rst |=> (curState == ST_WAIT));
  // R2
  wait_step_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_WAIT) |=> (curState == ($past(serialIn) ? ST_WAIT : ST_ONE)));
  // R3
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_ONE) |=> (curState == ($past(serialIn) ? ST_TWO : ST_ONE)));
  // R4
  two_step_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_TWO) |=> (curState == ($past(serialIn) ? ST_FULL : ST_ONE)));
  // R5
  full_step_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_FULL) |=> (curState == ($past(serialIn) ? ST_WAIT : ST_ONE)));
endmodule

// File: rtl/seq_progress_dp.sv
module seq_progress_dp
  import seq_progress_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stateStrobes_t     strobes,
  output logic [PROG_W-1:0] progress,
  output logic [STATE_W-1:0] stateOut
);
  always_comb begin
    progress[2] = strobes.hiBit & ~strobes.loBit;
    progress[1] = strobes.hiBit;
    progress[0] = strobes.hiBit | strobes.loBit;
  end

  assign stateOut = {strobes.hiBit, strobes.loBit};

  // R6
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (!progress[2] || progress[1]) && (!progress[1] || progress[0]));
  // R6
  full_only_after_two_chk: assert property (@(posedge clk) disable iff (rst)
    progress[2] |-> $past(progress[1]) && !$past(progress[2]));
endmodule

// File: rtl/seq_progress_top.sv
module seq_progress_top
  import seq_progress_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       serialIn,
  output logic [2:0] progress,
  output logic [1:0] stateOut
);
  stateStrobes_t strobes;

  seq_progress_ctrl ctrl_i (
    .clk(clk), .rst(rst), .serialIn(serialIn), .strobes(strobes)
  );

  seq_progress_dp dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .progress(progress), .stateOut(stateOut)
  );
endmodule

// File: tb/seq_progress_tb.sv
module seq_progress_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic [2:0] progress;
  logic [1:0] stateOut;
  int errors = 0;
  int checks = 0;
  int hist[$];
  int prevCount = 0;

  always #5 clk = ~clk;

  seq_progress_top dut_i (
    .clk(clk), .rst(rst), .serialIn(serialIn),
    .progress(progress), .stateOut(stateOut)
  );

  // Behavioural model: count of pattern bits matched, from the bit history
  function automatic int modelCount();
    int n = hist.size();
    if (n >= 3 && hist[n-3] == 0 && hist[n-2] == 1 && hist[n-1] == 1) return 3;
    if (n >= 2 && hist[n-2] == 0 && hist[n-1] == 1) return 2;
    if (n >= 1 && hist[n-1] == 0) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] codeOf(int c);
    case (c)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [2:0] thermoOf(int c);
    case (c)
      0: return 3'b000;
      1: return 3'b001;
      2: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic string reqOf(int c);
    case (c)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic checkOut(string req, logic [1:0] expSt, logic [2:0] expPr);
    checks++;
    if (stateOut !== expSt) begin
      errors++;
      $display("FAIL %s stateOut actual=%b expected=%b", req, stateOut, expSt);
    end
    checks++;
    if (progress !== expPr) begin
      errors++;
      $display("FAIL R6 progress actual=%b expected=%b (after %s step)", progress, expPr, req);
    end
  endtask

  // Called just after a falling edge; applies one bit and checks after the rising edge
  task automatic stepBit(int b, bit midToggle);
    int c;
    serialIn = b[0];
    if (midToggle) begin
      #2 serialIn = ~serialIn;
      #1;
      checks++;
      if (stateOut !== codeOf(prevCount) || progress !== thermoOf(prevCount)) begin
        errors++;
        $display("FAIL R7 outputs moved between edges actual=%b/%b expected=%b/%b",
                 stateOut, progress, codeOf(prevCount), thermoOf(prevCount));
      end
      serialIn = b[0];
    end
    @(posedge clk);
    hist.push_back(b);
    c = modelCount();
    #2 checkOut(reqOf(prevCount), codeOf(c), thermoOf(c));
    prevCount = c;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2 checkOut("R1", 2'b00, 3'b000);
    hist.delete();
    prevCount = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int pat1[] = '{1,1,0,0,1,1,0,1,1,1,0,1,0,1,1,0,1,1};
    doReset();
    foreach (pat1[i]) stepBit(pat1[i], 1'b0);
    // R7: toggle input mid-cycle in several states
    stepBit(0, 1'b1);
    stepBit(1, 1'b1);
    stepBit(1, 1'b1);
    stepBit(1, 1'b1);
    // R1: reset from the full-match state
    stepBit(0, 1'b0); stepBit(1, 1'b0); stepBit(1, 1'b0);
    doReset();
    // pseudo-random stream, back-to-back and overlapping occurrences
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stepBit(int'(lfsr[0]), (i % 37) == 5);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule